// File: doc/BRIEF.md
# Non-blocking Set-Associative Cache Tag Controller

This block holds the tag and line-state array of a set-associative cache and decides, for each request, what the cache must do. It does not store data and has no memory interface. A neighbouring datapath and a miss-handling unit act on its verdicts. Every line carries three state bits: valid, pending (a fill is on its way) and dirty. Each line also keeps its line address and two timestamps, one for the last use and one for the fetch. The timestamps come from a free-running cycle counter.

An access is looked up combinationally in the cycle it is presented, and the line state is updated at the next clock edge. In write-back mode a read miss claims a way at once: a free way if there is one, otherwise a replaced victim, whose address is handed out for writeback. The returning fill therefore always finds its slot. Later accesses to the same line merge as hits on a pending miss. In write-through mode nothing is allocated on a miss. The fill port places the line, evicting by least-recently-used or first-in-first-out order and returning the address of a dirty victim. A flush request drops every valid and dirty bit and reports how many dirty lines existed.

Top module: `nbc_tags`

## Requirements
- R1: The address is split into a line offset (the low log2(LINE_B) bits, ignored for lookup), a set index (the next log2(SETS) bits) and a tag (all remaining upper bits). Accesses that differ only in the offset behave identically.
- R2: After reset every line is invalid, not pending and clean. `acc_ack`, `wb_valid` and `evict_valid` are low while idle. The first read in write-back mode reports a miss, and a flush reports a dirty count of 0.
- R3: An access whose tag matches a valid, non-pending line in its set refreshes that line's last-use time and, if it is a write, sets the line dirty. The result code is 0 (hit) in write-back mode and 1 (write-through hit) in write-through mode.
- R4: An access whose tag matches a pending line reports code 2 (hit on pending miss). A write sets that line dirty, and the dirty bit survives the later fill.
- R5: Any miss in write-through mode, and any write miss in either mode, reports code 3 (miss, no writeback) and changes no line. Repeating the same access misses again.
- R6: A write-back read miss in a set whose ways are all pending reports code 5 (reservation failure) and changes nothing.
- R7: A write-back read miss with a free way (not valid and not pending) takes the lowest such way, marks it pending with the new tag, and reports code 3.
- R8: A write-back read miss with no free way picks a victim among the valid, non-pending ways. Under LRU (`cfg_fifo`=0) the oldest last-use time wins; under FIFO (`cfg_fifo`=1) the oldest fetch time wins; ties go to the lowest way. The victim becomes pending with the new tag, and the result is code 4. `wb_valid` is raised only if the victim was dirty, with `wb_addr` equal to the victim's line address and a zero offset.
- R9: In write-back mode a fill that matches a pending line makes it valid and not pending, keeps its dirty bit, records the fill's line address and stamps both times. A fill that matches a valid line is discarded, and a write-back fill never raises `evict_valid`.
- R10: In write-through mode a fill whose tag is already present does nothing. Otherwise it takes the lowest free way, or else a victim chosen by the rule of R8, and installs the line valid and clean. `evict_valid` is raised with `evict_addr` only when the victim was valid and dirty.
- R11: A flush clears the valid and dirty bits of every line but keeps pending lines. `flush_dirty_cnt` gives the number of lines that are valid and dirty in the flush cycle.
- R12: Flush outranks fill, and fill outranks access. `acc_ack` is high only for an access presented with neither fill nor flush, and a fill presented together with a flush has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cfg_fifo | input | 1 | Replacement order: 0 = LRU, 1 = FIFO |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Access byte address |
| acc_ack | output | 1 | Access accepted this cycle |
| acc_result | output | 3 | Outcome code (R3 to R8) |
| wb_valid | output | 1 | Dirty victim needs writeback |
| wb_addr | output | ADDR_W | Victim line address |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Fill byte address |
| evict_valid | output | 1 | Write-through fill displaced a dirty line |
| evict_addr | output | ADDR_W | Displaced line address |
| flush_req | input | 1 | Invalidate the whole array |
| flush_dirty_cnt | output | CNT_W | Valid and dirty lines at this moment |

## Verification
The hardest state to reach from the ports is a dirty writeback of a line whose dirty bit was set while the line was still pending, because the merge only shows up two steps later. The bench fills one set until every way is pending, writes to a pending line, fills the set, and reorders the last-use stamps with hits. It then switches to FIFO order so that the line merged earlier is the oldest fetch and becomes the victim. Reservation failure comes along the way, and so do the LRU and FIFO orders giving different victims in write-through mode.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef struct packed {
    logic v;
    logic r;
    logic d;
  } line_st_t;

  typedef enum logic [2:0] {
    RES_HIT     = 3'd0,
    RES_HIT_WT  = 3'd1,
    RES_PEND    = 3'd2,
    RES_MISS    = 3'd3,
    RES_MISS_WB = 3'd4,
    RES_FAIL    = 3'd5
  } acc_res_e;
endpackage

// File: rtl/nbc_addr_split.sv
module nbc_addr_split #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 2,
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int LA_W  = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [LA_W-1:0]   line_addr
);
  logic unused_offset_bits;

  assign set_idx            = addr[OFF_W +: SET_W];
  assign tag                = addr[ADDR_W-1 -: TAG_W];
  assign line_addr          = addr[ADDR_W-1:OFF_W];
  assign unused_offset_bits = ^addr[OFF_W-1:0];
endmodule

// File: rtl/nbc_way_match.sv
module nbc_way_match
  import nbc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0] row_tag [WAYS],
  input  line_st_t         row_st  [WAYS],
  input  logic [TAG_W-1:0] tag,
  output logic             found,
  output logic             pending,
  output logic [WAY_W-1:0] way
);
  // lowest way whose tag matches and that is valid or pending
  always_comb begin
    found   = 1'b0;
    pending = 1'b0;
    way     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && row_tag[w] == tag && (row_st[w].v || row_st[w].r)) begin
        found   = 1'b1;
        pending = row_st[w].r;
        way     = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/nbc_age_pick.sv
module nbc_age_pick #(
  parameter int WAYS   = 4,
  parameter int TIME_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]   cand,
  input  logic [TIME_W-1:0] age [WAYS],
  output logic              found,
  output logic [WAY_W-1:0]  way
);
  logic [TIME_W-1:0] best;

  // oldest stamp among candidates, strict compare keeps the lowest way on ties
  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (!found || age[w] < best)) begin
        found = 1'b1;
        way   = WAY_W'(w);
        best  = age[w];
      end
    end
  end
endmodule

// File: rtl/nbc_tags.sv
module nbc_tags
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int LINE_B = 16,
  parameter int TIME_W = 16,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int LA_W  = ADDR_W - OFF_W,
  localparam int CNT_W = $clog2(SETS * WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_back,
  input  logic              cfg_fifo,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ack,
  output logic [2:0]        acc_result,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              evict_valid,
  output logic [ADDR_W-1:0] evict_addr,
  input  logic              flush_req,
  output logic [CNT_W-1:0]  flush_dirty_cnt
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line storage
  logic [TIME_W-1:0] now_q;
  line_st_t          st_q    [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LA_W-1:0]   la_q    [SETS][WAYS];
  logic [TIME_W-1:0] used_q  [SETS][WAYS];
  logic [TIME_W-1:0] fetch_q [SETS][WAYS];

  // address fields
  logic [SET_W-1:0] a_set, f_set;
  logic [TAG_W-1:0] a_tag, f_tag;
  logic [LA_W-1:0]  a_la,  f_la;

  nbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_acc_split (
    .addr(acc_addr), .set_idx(a_set), .tag(a_tag), .line_addr(a_la));
  nbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_fill_split (
    .addr(fill_addr), .set_idx(f_set), .tag(f_tag), .line_addr(f_la));

  // selected set rows
  line_st_t          a_st  [WAYS];
  line_st_t          f_st  [WAYS];
  logic [TAG_W-1:0]  a_tags[WAYS];
  logic [TAG_W-1:0]  f_tags[WAYS];
  logic [TIME_W-1:0] a_age [WAYS];
  logic [TIME_W-1:0] f_age [WAYS];
  logic [WAYS-1:0]   a_free, a_cand, f_free, f_cand;
  logic              a_all_pend;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      a_st[w]   = st_q[a_set][w];
      f_st[w]   = st_q[f_set][w];
      a_tags[w] = tag_q[a_set][w];
      f_tags[w] = tag_q[f_set][w];
      a_age[w]  = cfg_fifo ? fetch_q[a_set][w] : used_q[a_set][w];
      f_age[w]  = cfg_fifo ? fetch_q[f_set][w] : used_q[f_set][w];
      a_free[w] = !a_st[w].v && !a_st[w].r;
      f_free[w] = !f_st[w].v && !f_st[w].r;
      a_cand[w] = a_st[w].v && !a_st[w].r;
      f_cand[w] = f_st[w].v && !f_st[w].r;
    end
    a_all_pend = 1'b1;
    for (int w = 0; w < WAYS; w++) a_all_pend = a_all_pend && a_st[w].r;
  end

  logic             am_found, am_pend, fm_found, fm_pend;
  logic [WAY_W-1:0] am_way, fm_way;
  logic             af_found, ff_found, av_found, fv_found;
  logic [WAY_W-1:0] af_way, ff_way, av_way, fv_way;

  nbc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_acc_match (
    .row_tag(a_tags), .row_st(a_st), .tag(a_tag),
    .found(am_found), .pending(am_pend), .way(am_way));
  nbc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .row_tag(f_tags), .row_st(f_st), .tag(f_tag),
    .found(fm_found), .pending(fm_pend), .way(fm_way));

  // lowest free way per side
  always_comb begin
    af_found = 1'b0; af_way = '0;
    ff_found = 1'b0; ff_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!af_found && a_free[w]) begin af_found = 1'b1; af_way = WAY_W'(w); end
      if (!ff_found && f_free[w]) begin ff_found = 1'b1; ff_way = WAY_W'(w); end
    end
  end

  nbc_age_pick #(.WAYS(WAYS), .TIME_W(TIME_W)) u_acc_victim (
    .cand(a_cand), .age(a_age), .found(av_found), .way(av_way));
  nbc_age_pick #(.WAYS(WAYS), .TIME_W(TIME_W)) u_fill_victim (
    .cand(f_cand), .age(f_age), .found(fv_found), .way(fv_way));

  // decision and next-state request
  acc_res_e         res;
  logic             fill_ack;
  logic             wr_en, wr_tag_en, wr_la_en, wr_used_en, wr_fetch_en;
  logic [SET_W-1:0] wr_set;
  logic [WAY_W-1:0] wr_way;
  line_st_t         wr_st;
  logic [TAG_W-1:0] wr_tag;
  logic [LA_W-1:0]  wr_la;

  always_comb begin
    acc_ack     = acc_valid && !fill_valid && !flush_req;
    fill_ack    = fill_valid && !flush_req;
    res         = RES_MISS;
    wb_valid    = 1'b0;
    wb_addr     = '0;
    evict_valid = 1'b0;
    evict_addr  = '0;
    wr_en       = 1'b0;
    wr_tag_en   = 1'b0;
    wr_la_en    = 1'b0;
    wr_used_en  = 1'b0;
    wr_fetch_en = 1'b0;
    wr_set      = '0;
    wr_way      = '0;
    wr_st       = '0;
    wr_tag      = '0;
    wr_la       = '0;
    if (fill_ack) begin
      wr_set = f_set;
      wr_tag = f_tag;
      wr_la  = f_la;
      if (cfg_write_back) begin
        if (fm_found && fm_pend) begin
          wr_en       = 1'b1;
          wr_way      = fm_way;
          wr_st.v     = 1'b1;
          wr_st.r     = 1'b0;
          wr_st.d     = f_st[fm_way].d;
          wr_la_en    = 1'b1;
          wr_used_en  = 1'b1;
          wr_fetch_en = 1'b1;
        end
      end else if (!fm_found) begin
        if (ff_found) begin
          wr_en  = 1'b1;
          wr_way = ff_way;
        end else if (fv_found) begin
          wr_en       = 1'b1;
          wr_way      = fv_way;
          evict_valid = f_st[fv_way].d;
          evict_addr  = {la_q[f_set][fv_way], {OFF_W{1'b0}}};
        end
        wr_st.v     = 1'b1;
        wr_tag_en   = wr_en;
        wr_la_en    = wr_en;
        wr_used_en  = wr_en;
        wr_fetch_en = wr_en;
      end
    end else if (acc_ack) begin
      wr_set = a_set;
      wr_tag = a_tag;
      wr_la  = a_la;
      if (am_found) begin
        res     = am_pend ? RES_PEND : (cfg_write_back ? RES_HIT : RES_HIT_WT);
        wr_en   = 1'b1;
        wr_way  = am_way;
        wr_st   = a_st[am_way];
        wr_st.d = a_st[am_way].d || acc_write;
        wr_used_en = !am_pend;
      end else if (!cfg_write_back || acc_write) begin
        res = RES_MISS;
      end else if (a_all_pend) begin
        res = RES_FAIL;
      end else if (af_found) begin
        res       = RES_MISS;
        wr_en     = 1'b1;
        wr_way    = af_way;
        wr_st.r   = 1'b1;
        wr_tag_en = 1'b1;
        wr_la_en  = 1'b1;
      end else begin
        res       = RES_MISS_WB;
        wr_en     = av_found;
        wr_way    = av_way;
        wr_st.r   = 1'b1;
        wr_tag_en = av_found;
        wr_la_en  = av_found;
        wb_valid  = av_found && a_st[av_way].d;
        wb_addr   = {la_q[a_set][av_way], {OFF_W{1'b0}}};
      end
    end
    acc_result = res;
  end

  // dirty count over the whole array
  always_comb begin
    flush_dirty_cnt = '0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (st_q[s][w].v && st_q[s][w].d) flush_dirty_cnt = flush_dirty_cnt + 1'b1;
  end

  // state bits and timebase, reset
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      now_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (flush_req) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) begin
            st_q[s][w].v <= 1'b0;
            st_q[s][w].d <= 1'b0;
          end
      end else if (wr_en) begin
        st_q[wr_set][wr_way] <= wr_st;
      end
    end
  end

  // payload fields, enabled writes without reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en)   tag_q[wr_set][wr_way]   <= wr_tag;
    if (wr_en && wr_la_en)    la_q[wr_set][wr_way]    <= wr_la;
    if (wr_en && wr_used_en)  used_q[wr_set][wr_way]  <= now_q;
    if (wr_en && wr_fetch_en) fetch_q[wr_set][wr_way] <= now_q;
  end
endmodule

// File: rtl/nbc_tags_chk.sv
module nbc_tags_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_write_back,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_ack,
  input logic [2:0]       acc_result,
  input logic             wb_valid,
  input logic             fill_valid,
  input logic             evict_valid,
  input logic             flush_req,
  input logic [CNT_W-1:0] flush_dirty_cnt
);
  assert_wt_no_plain_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack && !cfg_write_back |-> acc_result != 3'd0 && acc_result != 3'd4 && acc_result != 3'd5);

  assert_write_never_evicts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack && acc_write |-> acc_result != 3'd4 && acc_result != 3'd5);

  assert_fail_only_wb_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack && acc_result == 3'd5 |-> cfg_write_back && !acc_write);

  assert_wb_with_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> acc_ack && acc_result == 3'd4);

  assert_evict_wt_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !cfg_write_back && fill_valid && !flush_req);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req || flush_dirty_cnt == '0);

  assert_ack_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> acc_valid && !fill_valid && !flush_req);
endmodule

bind nbc_tags nbc_tags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_write_back),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_ack(acc_ack),
  .acc_result(acc_result), .wb_valid(wb_valid), .fill_valid(fill_valid),
  .evict_valid(evict_valid), .flush_req(flush_req), .flush_dirty_cnt(flush_dirty_cnt));

// File: tb/nbc_tags_bench.sv
`timescale 1ns/100ps
module nbc_tags_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_write_back, cfg_fifo;
  logic        acc_valid, acc_write;
  logic [15:0] acc_addr;
  logic        acc_ack;
  logic [2:0]  acc_result;
  logic        wb_valid;
  logic [15:0] wb_addr;
  logic        fill_valid;
  logic [15:0] fill_addr;
  logic        evict_valid;
  logic [15:0] evict_addr;
  logic        flush_req;
  logic [4:0]  flush_dirty_cnt;

  always #2.5 clk = ~clk;

  nbc_tags u_nbc_tags (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_write_back), .cfg_fifo(cfg_fifo),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_ack(acc_ack), .acc_result(acc_result), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .evict_valid(evict_valid),
    .evict_addr(evict_addr), .flush_req(flush_req), .flush_dirty_cnt(flush_dirty_cnt));

  typedef struct {
    bit          ack;
    logic [2:0]  res;
    bit          wbv;
    logic [15:0] wba;
    bit          is_fill;
    bit          ev;
    logic [15:0] eva;
    bit          is_flush;
    logic [4:0]  cnt;
    int          req;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_err    = 0;
  bit   done     = 1'b0;

  localparam logic [2:0] HIT = 3'd0, HWT = 3'd1, PEND = 3'd2, MISS = 3'd3, MWB = 3'd4, RFAIL = 3'd5;

  function automatic logic [15:0] mk(int tg, int st, int off = 0);
    return 16'((tg << 6) | (st << 4) | off);
  endfunction

  task automatic chk(int req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t blank(int req);
    exp_t e;
    e = '{default: 0};
    e.req = req;
    return e;
  endfunction

  task automatic t_acc(bit wr, logic [15:0] a, logic [2:0] res, bit wbv, logic [15:0] wba, int req);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; fill_valid = 1'b0; flush_req = 1'b0;
    e = blank(req); e.ack = 1'b1; e.res = res; e.wbv = wbv; e.wba = wba;
    sb.push_back(e);
  endtask

  task automatic t_fill(logic [15:0] a, bit ev, logic [15:0] eva, bit with_acc, logic [15:0] aa, int req);
    exp_t e;
    @(negedge clk);
    acc_valid = with_acc; acc_write = 1'b0; acc_addr = aa; fill_valid = 1'b1; fill_addr = a; flush_req = 1'b0;
    e = blank(req); e.is_fill = 1'b1; e.ev = ev; e.eva = eva;
    sb.push_back(e);
  endtask

  task automatic t_flush(logic [4:0] cnt, bit with_acc, logic [15:0] aa, bit with_fill, logic [15:0] fa, int req);
    exp_t e;
    @(negedge clk);
    acc_valid = with_acc; acc_write = 1'b0; acc_addr = aa; fill_valid = with_fill; fill_addr = fa; flush_req = 1'b1;
    e = blank(req); e.is_flush = 1'b1; e.cnt = cnt;
    sb.push_back(e);
  endtask

  task automatic t_cfg(bit wbm, bit fifo);
    @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0; flush_req = 1'b0;
    cfg_write_back = wbm; cfg_fifo = fifo;
  endtask

  // monitor: pops one expected item per stimulus cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (acc_valid || fill_valid || flush_req) begin
        if (sb.size() == 0) begin
          chk(12, "scoreboard empty", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(e.req, "acc_ack", acc_ack, e.ack);
          if (e.ack) begin
            chk(e.req, "acc_result", acc_result, e.res);
            chk(e.req, "wb_valid", wb_valid, e.wbv);
            if (e.wbv) chk(e.req, "wb_addr", wb_addr, e.wba);
          end
          if (e.is_fill) begin
            chk(e.req, "evict_valid", evict_valid, e.ev);
            if (e.ev) chk(e.req, "evict_addr", evict_addr, e.eva);
          end
          if (e.is_flush) chk(e.req, "flush_dirty_cnt", flush_dirty_cnt, e.cnt);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_write_back = 1'b1; cfg_fifo = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    fill_valid = 1'b0; fill_addr = '0; flush_req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(2, "idle acc_ack", acc_ack, 0);        // R2
    chk(2, "idle wb_valid", wb_valid, 0);      // R2
    chk(2, "idle evict_valid", evict_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // write-back, LRU, set 1
    t_flush(5'd0, 0, 0, 0, 0, 2);              // R2 empty array
    t_acc(0, mk(1,1), MISS, 0, 0, 7);          // R7 way0 reserved (also R2)
    t_acc(0, mk(1,1), PEND, 0, 0, 7);          // R7
    t_acc(1, mk(1,1), PEND, 0, 0, 4);          // R4 write merges, dirty
    t_acc(0, mk(2,1), MISS, 0, 0, 7);
    t_acc(0, mk(3,1), MISS, 0, 0, 7);
    t_acc(0, mk(4,1), MISS, 0, 0, 7);
    t_acc(0, mk(5,1), RFAIL, 0, 0, 6);         // R6 every way pending
    t_acc(1, mk(5,1), MISS, 0, 0, 5);          // R5 write miss
    t_fill(mk(1,1,3), 0, 0, 0, 0, 9);          // R9
    t_fill(mk(1,1), 0, 0, 0, 0, 9);            // R9 discarded
    t_fill(mk(2,1), 0, 0, 0, 0, 9);
    t_fill(mk(3,1), 0, 0, 0, 0, 9);
    t_fill(mk(4,1), 0, 0, 0, 0, 9);
    t_acc(0, mk(1,1), HIT, 0, 0, 3);           // R3
    t_acc(0, mk(1,1,15), HIT, 0, 0, 1);        // R1 offset ignored
    t_acc(0, mk(2,1), HIT, 0, 0, 3);
    t_acc(0, mk(6,1), MWB, 0, 0, 8);           // R8 LRU victim way2, clean
    t_cfg(1, 1);
    t_acc(0, mk(7,1), MWB, 1, mk(1,1), 8);     // R8 FIFO victim way0, dirty from R4 merge
    t_acc(1, mk(4,1), HIT, 0, 0, 3);           // R3 write hit sets dirty
    t_flush(5'd1, 0, 0, 0, 0, 11);             // R11 one dirty line
    t_acc(0, mk(4,1), MISS, 0, 0, 11);         // R11 line gone
    t_acc(0, mk(6,1), PEND, 0, 0, 11);         // R11 pending kept
    t_flush(5'd0, 0, 0, 0, 0, 11);
    // priority
    t_fill(mk(6,1), 0, 0, 1, mk(10,2), 12);    // R12 access loses to fill
    t_acc(0, mk(6,1), HIT, 0, 0, 12);
    t_acc(0, mk(10,2), MISS, 0, 0, 12);        // R12 blocked access left nothing
    t_flush(5'd0, 1, mk(11,2), 0, 0, 12);
    t_acc(0, mk(11,2), MISS, 0, 0, 12);
    t_flush(5'd0, 0, 0, 1, mk(4,1), 12);       // R12 fill lost to flush
    t_acc(0, mk(4,1), PEND, 0, 0, 12);

    // write-through, FIFO, set 3
    t_cfg(0, 1);
    t_acc(0, mk(1,3), MISS, 0, 0, 5);          // R5
    t_acc(0, mk(1,3), MISS, 0, 0, 5);          // R5 no allocation
    t_acc(1, mk(9,3), MISS, 0, 0, 5);
    t_fill(mk(1,3), 0, 0, 0, 0, 10);           // R10
    t_fill(mk(2,3), 0, 0, 0, 0, 10);
    t_fill(mk(3,3), 0, 0, 0, 0, 10);
    t_fill(mk(4,3), 0, 0, 0, 0, 10);
    t_fill(mk(1,3), 0, 0, 0, 0, 10);           // R10 already present
    t_acc(0, mk(1,3), HWT, 0, 0, 3);           // R3
    t_acc(1, mk(2,3), HWT, 0, 0, 3);
    t_fill(mk(5,3), 0, 0, 0, 0, 10);           // R10 FIFO victim way0 clean
    t_fill(mk(6,3), 1, mk(2,3), 0, 0, 10);     // R10 dirty victim way1
    t_acc(1, mk(3,3), HWT, 0, 0, 3);
    t_cfg(0, 0);
    t_fill(mk(7,3), 0, 0, 0, 0, 8);            // R8 LRU picks way3, clean
    t_cfg(0, 1);
    t_fill(mk(8,3), 1, mk(3,3), 0, 0, 8);      // R8 FIFO picks dirty way2
    t_acc(0, mk(3,3), MISS, 0, 0, 10);
    t_cfg(0, 1);
    repeat (3) @(negedge clk);

    if (sb.size() != 0) chk(12, "items left", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule